// File: doc/BRIEF.md
# Three-Wire Serial Register-Access Slave

This block is the control-port slave of a converter-style device. A host reaches a small internal register file through three wires: an active-low chip select, a serial clock and one shared data line. The data line is split at the block's edge into an input, an output and an output enable. Each transaction opens with a 16-bit instruction word. The word holds the access direction, a transfer-length code and a 13-bit start address. A data phase of whole bytes follows, and an internal address counter steps once per byte.

All pins are sampled by the system clock `clk`. Serial clock and chip-select edges are found by comparing each pin with its value one system cycle earlier. The serial clock idles low. Incoming bits are taken on its rising edges, and read data is updated on its falling edges.

The block starts in pin-control mode. The first chip-select fall moves it into serial-control mode for good. At that moment the level on the data line is stored as the output-standard select. After that, the select changes only when its own register bit is written.

Top module: `spiRegSlave`

## Requirements
- R1: A chip-select fall starts a transaction. The next 16 rising serial-clock edges shift in the instruction word, most significant bit first. Chip select going high ends the transaction at any point.
- R2: In the instruction word, bit 15 set means read and clear means write. Bits 14:13 are the length code. Bits 12:0 are the first register address.
- R3: Length code 00 moves 1 byte, 01 moves 2 bytes and 10 moves 3 bytes. Serial-clock edges after those bytes have no effect until chip select rises. Code 11 keeps moving bytes until chip select rises.
- R4: The address counter steps by one after each data byte and wraps from 0x1FFF to 0x0000.
- R5: After the eighth bit of a write byte is captured, `regWrEn` pulses for exactly one cycle with `regWrAddr` and `regWrData`. The register is updated at the same time. A partial byte cut off by chip select is discarded.
- R6: Read data leaves on `sdioOut` most significant bit first and changes after serial-clock falling edges. `sdioOe` is high only during the read data phase. It is low during the instruction phase, during writes, after the last counted byte, and once chip select is high.
- R7: Addresses at or above NUM_REGS (24 by default) are not implemented. Writes to them give no strobe and change nothing, and reads from them return 0x00.
- R8: After reset `serialMode` is 0. The first chip-select fall sets it to 1, and it stays 1 until reset.
- R9: `outStdSel` takes the `sdioIn` level seen at the first chip-select fall. Later falls do not change it. It is bit 0 of register 20 (STD_REG, STD_BIT) and follows any write to that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idle low |
| sdioIn | input | 1 | Input side of the shared data line |
| sdioOut | output | 1 | Output side of the shared data line |
| sdioOe | output | 1 | Drive enable for the shared data line |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrAddr | output | 13 | Address of the register just written |
| regWrData | output | 8 | Byte just written |
| serialMode | output | 1 | High once serial-control mode is active |
| outStdSel | output | 1 | Output-standard select (register bit) |

## Verification
Some properties are checked by assertions on every cycle:
- serial mode never drops back once set;
- the drive enable is confined to read data phases and falls one cycle after chip select goes high;
- the write strobe is always a single-cycle pulse;
- the byte counter never passes a fixed length code;
- every byte step moves the address counter by exactly one;
- the output-standard select only moves at mode entry or on a write.

Other behaviour can only be shown by the bench's scenarios:
- the decoded fields and the bit order;
- the data that reads return;
- surplus bytes, partial bytes and out-of-range bytes having no effect;
- the address wrap from 0x1FFF to 0x0000;
- the level actually captured on the data line at mode entry.

// File: rtl/spiRegPkg.sv
package spiRegPkg;
  localparam int ADDR_W  = 13;
  localparam int INSTR_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INSTR,
    ST_DATA,
    ST_DONE
  } xferState_t;

  typedef struct packed {
    logic shiftIn;
    logic loadInstr;
    logic wrByte;
    logic incAddr;
    logic loadRd;
    logic shiftRd;
    logic enterSerial;
  } ctrlStb_t;
endpackage

// File: rtl/spiCtrlFsm.sv
module spiCtrlFsm
  import spiRegPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       isRead,
  input  logic [1:0] lenCode,
  output ctrlStb_t   stb,
  output logic       serialMode,
  output logic       sdioOe
);
  localparam int BIT_W = $clog2(INSTR_W);

  xferState_t       state;
  logic [BIT_W-1:0] bitCnt;
  logic [1:0]       byteCnt;
  logic             csPrev, sclkPrev;
  logic             csFall, sclkRise, sclkFall;
  logic             instrLast, byteLast, lenReached;

  assign csFall     = csPrev & ~csN;
  assign sclkRise   = sclk & ~sclkPrev & ~csN;
  assign sclkFall   = ~sclk & sclkPrev & ~csN;
  assign instrLast  = (bitCnt == BIT_W'(INSTR_W - 1));
  assign byteLast   = (bitCnt == BIT_W'(7));
  assign lenReached = (lenCode != 2'b11) && (byteCnt == lenCode);

  always_comb begin
    stb             = '0;
    stb.shiftIn     = sclkRise && (state == ST_INSTR || state == ST_DATA);
    stb.loadInstr   = sclkRise && state == ST_INSTR && instrLast;
    stb.wrByte      = sclkRise && state == ST_DATA && !isRead && byteLast;
    stb.incAddr     = sclkRise && state == ST_DATA && byteLast;
    stb.loadRd      = sclkFall && state == ST_DATA && isRead && bitCnt == '0;
    stb.shiftRd     = sclkFall && state == ST_DATA && isRead && bitCnt != '0;
    stb.enterSerial = csFall && !serialMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev     <= 1'b1;
      sclkPrev   <= 1'b0;
      state      <= ST_IDLE;
      bitCnt     <= '0;
      byteCnt    <= '0;
      serialMode <= 1'b0;
      sdioOe     <= 1'b0;
    end else begin
      csPrev   <= csN;
      sclkPrev <= sclk;
      if (csFall) begin
        serialMode <= 1'b1;
        state      <= ST_INSTR;
        bitCnt     <= '0;
        byteCnt    <= '0;
        sdioOe     <= 1'b0;
      end else if (csN) begin
        state  <= ST_IDLE;
        sdioOe <= 1'b0;
      end else begin
        if (sclkRise) begin
          case (state)
            ST_INSTR: begin
              if (instrLast) begin
                state  <= ST_DATA;
                bitCnt <= '0;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
            ST_DATA: begin
              if (byteLast) begin
                bitCnt  <= '0;
                byteCnt <= byteCnt + 1'b1;
                if (lenReached) state <= ST_DONE;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
            default: ;
          endcase
        end
        if (sclkFall) begin
          if (stb.loadRd) sdioOe <= 1'b1;
          if (state == ST_DONE) sdioOe <= 1'b0;
        end
      end
    end
  end

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    serialMode |=> serialMode); // R8
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    sdioOe |-> (isRead && (state == ST_DATA || state == ST_DONE))); // R6
  AST_OE_DROP_ON_CS: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !sdioOe); // R6
  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && lenCode != 2'b11) |-> (byteCnt <= lenCode)); // R3
endmodule

// File: rtl/spiCtrlData.sv
module spiCtrlData
  import spiRegPkg::*;
#(
  parameter int NUM_REGS = 24,
  parameter int STD_REG  = 20,
  parameter int STD_BIT  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdioIn,
  input  ctrlStb_t          stb,
  input  logic              serialMode,
  output logic              isRead,
  output logic [1:0]        lenCode,
  output logic              sdioOut,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [7:0]        regWrData,
  output logic              outStdSel
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_REGS - 1);

  logic [7:0]         regs [NUM_REGS];
  logic [INSTR_W-1:0] shiftReg;
  logic [INSTR_W-1:0] instrWord;
  logic [7:0]         byteIn, rdByte, txShift;
  logic [ADDR_W-1:0]  addrCnt;
  logic               inRange;

  assign instrWord = {shiftReg[INSTR_W-2:0], sdioIn};
  assign byteIn    = {shiftReg[6:0], sdioIn};
  assign inRange   = (addrCnt <= LAST_IDX);
  assign rdByte    = inRange ? regs[addrCnt[IDX_W-1:0]] : 8'h00;
  assign sdioOut   = txShift[7];
  assign outStdSel = regs[STD_REG][STD_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      isRead    <= 1'b0;
      lenCode   <= '0;
      addrCnt   <= '0;
      txShift   <= '0;
      regWrEn   <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      regWrEn <= 1'b0;
      if (stb.shiftIn) shiftReg <= instrWord;
      if (stb.loadInstr) begin
        isRead  <= instrWord[15];
        lenCode <= instrWord[14:13];
        addrCnt <= instrWord[ADDR_W-1:0];
      end else if (stb.incAddr) begin
        addrCnt <= addrCnt + 1'b1;
      end
      if (stb.loadRd)       txShift <= rdByte;
      else if (stb.shiftRd) txShift <= {txShift[6:0], 1'b0};
      if (stb.wrByte && inRange) begin
        regs[addrCnt[IDX_W-1:0]] <= byteIn;
        regWrEn   <= 1'b1;
        regWrAddr <= addrCnt;
        regWrData <= byteIn;
      end
      if (stb.enterSerial) regs[STD_REG][STD_BIT] <= sdioIn;
    end
  end

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.incAddr |=> (addrCnt == $past(addrCnt) + 13'd1)); // R4
  AST_STD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(serialMode) && !$past(stb.wrByte)) |-> $stable(outStdSel)); // R9
endmodule

// File: rtl/spiRegSlave.sv
module spiRegSlave
  import spiRegPkg::*;
#(
  parameter int NUM_REGS = 24,
  parameter int STD_REG  = 20,
  parameter int STD_BIT  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdioIn,
  output logic              sdioOut,
  output logic              sdioOe,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [7:0]        regWrData,
  output logic              serialMode,
  output logic              outStdSel
);
  ctrlStb_t   stb;
  logic       isRead;
  logic [1:0] lenCode;

  spiCtrlFsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .csN        (csN),
    .sclk       (sclk),
    .isRead     (isRead),
    .lenCode    (lenCode),
    .stb        (stb),
    .serialMode (serialMode),
    .sdioOe     (sdioOe)
  );

  spiCtrlData #(
    .NUM_REGS (NUM_REGS),
    .STD_REG  (STD_REG),
    .STD_BIT  (STD_BIT)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .sdioIn     (sdioIn),
    .stb        (stb),
    .serialMode (serialMode),
    .isRead     (isRead),
    .lenCode    (lenCode),
    .sdioOut    (sdioOut),
    .regWrEn    (regWrEn),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData),
    .outStdSel  (outStdSel)
  );
endmodule

// File: tb/spiRegSlave_tb.sv
module spiRegSlave_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b0;
  logic        sdioIn = 1'b0;
  logic        sdioOut, sdioOe, regWrEn, serialMode, outStdSel;
  logic [12:0] regWrAddr;
  logic [7:0]  regWrData;

  int checks = 0;
  int errors = 0;
  int wrCount = 0;
  logic [12:0] lastAddr;
  logic [7:0]  lastData;
  logic [7:0]  txBuf [8];
  logic [7:0]  rxBuf [8];
  logic        oeSeenWr, oeAllRd;

  always #5 clk = ~clk;

  spiRegSlave u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData),
    .serialMode(serialMode), .outStdSel(outStdSel)
  );

  always @(posedge clk) begin
    if (regWrEn) begin
      wrCount  <= wrCount + 1;
      lastAddr <= regWrAddr;
      lastData <= regWrData;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startXfer(input logic level);
    sdioIn = level;
    waitClk(2);
    csN = 1'b0;
    waitClk(4);
    oeSeenWr = 1'b0;
    oeAllRd  = 1'b1;
  endtask

  task automatic endXfer();
    waitClk(4);
    csN = 1'b1;
    waitClk(6);
  endtask

  task automatic sendBit(input logic b);
    sdioIn = b;
    waitClk(4);
    oeSeenWr = oeSeenWr | sdioOe;
    sclk = 1'b1;
    waitClk(4);
    sclk = 1'b0;
  endtask

  task automatic sendInstr(input logic rd, input logic [1:0] len, input logic [12:0] addr);
    logic [15:0] w;
    w = {rd, len, addr};
    for (int i = 15; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
  endtask

  task automatic recvByte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      waitClk(4);
      b[i] = sdioOut;
      oeAllRd = oeAllRd & sdioOe;
      sclk = 1'b1;
      waitClk(4);
      sclk = 1'b0;
    end
  endtask

  task automatic doWrite(input logic [1:0] len, input logic [12:0] addr, input int n);
    startXfer(1'b0);
    sendInstr(1'b0, len, addr);
    for (int k = 0; k < n; k++) sendByte(txBuf[k]);
    endXfer();
  endtask

  task automatic doRead(input logic [1:0] len, input logic [12:0] addr, input int n);
    startXfer(1'b0);
    sendInstr(1'b1, len, addr);
    oeSeenWr = 1'b0;
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      recvByte(b);
      rxBuf[k] = b;
    end
    endXfer();
  endtask

  task automatic testReset();
    chk("R8 reset serialMode", serialMode, 0);
    chk("R6 reset sdioOe", sdioOe, 0);
    chk("R9 reset outStdSel", outStdSel, 0);
    chk("R5 reset regWrEn", regWrEn, 0);
  endtask

  task automatic testModeEntry();
    startXfer(1'b1);
    endXfer();
    chk("R8 serialMode after first fall", serialMode, 1);
    chk("R9 outStdSel captured high", outStdSel, 1);
  endtask

  task automatic testSingle();
    int w0;
    w0 = wrCount;
    txBuf[0] = 8'hA5;
    doWrite(2'b00, 13'd3, 1);
    chk("R5 one strobe per byte", wrCount - w0, 1);
    chk("R5 strobe address", lastAddr, 3);
    chk("R5 strobe data", lastData, 8'hA5);
    chk("R6 no drive during write", oeSeenWr, 0);
    doRead(2'b00, 13'd3, 1);
    chk("R2 read single byte", rxBuf[0], 8'hA5);
    chk("R6 oe high while reading", oeAllRd, 1);
    chk("R6 oe low after chip select", sdioOe, 0);
  endtask

  task automatic testFixedLen();
    int w0;
    w0 = wrCount;
    txBuf[0] = 8'h11; txBuf[1] = 8'h22; txBuf[2] = 8'h33; txBuf[3] = 8'h44;
    doWrite(2'b10, 13'd5, 4);
    chk("R3 three strobes for code 10", wrCount - w0, 3);
    startXfer(1'b0);
    sendInstr(1'b1, 2'b01, 13'd5);
    for (int k = 0; k < 2; k++) begin
      logic [7:0] b;
      recvByte(b);
      rxBuf[k] = b;
    end
    waitClk(4);
    chk("R6 oe drops after counted bytes", sdioOe, 0);
    endXfer();
    chk("R3 code 01 byte0", rxBuf[0], 8'h11);
    chk("R4 code 01 byte1", rxBuf[1], 8'h22);
    doRead(2'b11, 13'd5, 4);
    chk("R4 stream byte2", rxBuf[2], 8'h33);
    chk("R3 surplus byte ignored", rxBuf[3], 8'h00);
  endtask

  task automatic testStream();
    int w0;
    w0 = wrCount;
    for (int k = 0; k < 5; k++) txBuf[k] = 8'hC1 + 8'(k);
    doWrite(2'b11, 13'd10, 5);
    chk("R3 code 11 five strobes", wrCount - w0, 5);
    chk("R4 last streamed address", lastAddr, 14);
    doRead(2'b11, 13'd10, 5);
    for (int k = 0; k < 5; k++) chk("R3 streamed readback", rxBuf[k], 8'hC1 + 8'(k));
  endtask

  task automatic testPartial();
    int w0;
    w0 = wrCount;
    startXfer(1'b0);
    sendInstr(1'b0, 2'b00, 13'd2);
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    endXfer();
    chk("R5 partial byte no strobe", wrCount - w0, 0);
    doRead(2'b00, 13'd2, 1);
    chk("R1 partial byte not stored", rxBuf[0], 8'h00);
  endtask

  task automatic testRangeWrap();
    int w0;
    w0 = wrCount;
    txBuf[0] = 8'h9E;
    doWrite(2'b00, 13'd100, 1);
    chk("R7 out-of-range write no strobe", wrCount - w0, 0);
    doRead(2'b00, 13'd100, 1);
    chk("R7 out-of-range read zero", rxBuf[0], 8'h00);
    txBuf[0] = 8'h77; txBuf[1] = 8'h5C;
    w0 = wrCount;
    doWrite(2'b01, 13'h1FFF, 2);
    chk("R4 wrap write strobes", wrCount - w0, 1);
    chk("R4 wrap write address", lastAddr, 0);
    doRead(2'b01, 13'h1FFF, 2);
    chk("R7 read at 0x1FFF zero", rxBuf[0], 8'h00);
    chk("R4 wrap read reg0", rxBuf[1], 8'h5C);
  endtask

  task automatic testStdSel();
    startXfer(1'b0);
    endXfer();
    chk("R9 later fall keeps select", outStdSel, 1);
    chk("R8 mode stays serial", serialMode, 1);
    doRead(2'b00, 13'd20, 1);
    chk("R9 captured bit in register", rxBuf[0], 8'h01);
    txBuf[0] = 8'h00;
    doWrite(2'b00, 13'd20, 1);
    chk("R9 write clears select", outStdSel, 0);
    txBuf[0] = 8'h03;
    doWrite(2'b00, 13'd20, 1);
    chk("R9 write sets select", outStdSel, 1);
  endtask

  initial begin
    waitClk(3);
    testReset();
    rstN = 1'b1;
    waitClk(3);
    testReset();
    testModeEntry();
    testSingle();
    testFixedLen();
    testStream();
    testPartial();
    testRangeWrap();
    testStdSel();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule